// File: doc/BRIEF.md
# Floating-Point Structural Hazard Tracker

This block sits beside the issue stage of an in-order core and keeps track of three shared floating-point resources: the multiply pipe, the add pipe and a divide/square-root unit that is not pipelined. Each cycle the issue logic presents the class of its candidate floating-point operation. The tracker answers at once whether that operation may issue, given what earlier operations still hold. The arithmetic itself is done elsewhere.

Double-precision multiplies keep the multiply pipe for several cycles after issue. During that time only other multiplies are held back, and adds, moves and divides go ahead. A divide keeps the divider busy for most of its latency. Its result arrives long after younger operations have finished, so the tracker raises a one-cycle completion pulse that carries the destination tag of the divide. A flush input drops all pending holds and cancels divide results that have not yet been reported.

Top module: `fp_hazard_tracker`

## Requirements
- R1: After reset no resource is busy, div_done is low, and issue_ok is high for every class.
- R2: op_class encoding: 0 none, 1 add, 2 constant move, 3 single-precision multiply/MAC, 4 double-precision multiply/MAC, 5 double-precision fused multiply-add, 6 vector multiply, 7 single-precision divide, 8 double-precision divide, 9 and 10..15 register move or other. An operation is accepted in a cycle when op_valid and issue_ok are both high, and only accepted operations claim resources.
- R3: An accepted class 4 operation holds the multiply pipe in its issue cycle and the 3 cycles after it. Class 5 holds it in its issue cycle and the 4 cycles after it. mul_busy is high in every cycle in which the pipe is held.
- R4: A multiply class (3, 4, 5 or 6) gets issue_ok low while an earlier operation still holds the multiply pipe.
- R5: Classes 1, 2, 7, 8 and 9..15 are never refused because of the multiply pipe hold.
- R6: An accepted vector multiply holds the multiply pipe in its issue cycle and the cycle after. In that following cycle it also holds both issue slots, so issue_ok is low for every class.
- R7: add_busy is high exactly in the cycles in which a class 1 or class 2 operation is accepted.
- R8: An accepted class 7 divide holds the divider in its issue cycle and the 13 cycles after it, and class 8 in its issue cycle and the 28 cycles after it. A divide presented while the divider is held gets issue_ok low. div_busy is high in every held cycle.
- R9: div_done pulses for exactly one cycle, carrying the divide's op_tag on div_done_tag, 16 cycles after a class 7 issue and 31 cycles after a class 8 issue, counting the issue cycle as 0. A second divide may issue while the first result is still pending, and both results are reported.
- R10: While flush is high, issue_ok is low for every class. After a flush cycle the multiply pipe, the divider and the vector slot hold are free, and no pending divide result is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Drops all holds and pending divide results |
| op_valid | input | 1 | A candidate operation is presented |
| op_class | input | 4 | Class of the candidate operation (encoding in R2) |
| op_tag | input | TAG_W | Destination tag of the candidate, used by divides |
| issue_ok | output | 1 | The presented class may issue this cycle |
| mul_busy | output | 1 | Multiply pipe in use this cycle |
| add_busy | output | 1 | Add pipe in use this cycle |
| div_busy | output | 1 | Divider in use this cycle |
| div_done | output | 1 | A divide result completes this cycle |
| div_done_tag | output | TAG_W | Tag of the completing divide |

## Verification
The bench builds the tracker with the default hold and latency values, so the full 31-cycle double-precision divide is observed. Those values also let a single-precision divide be followed two cycles before its result by a double-precision one, which fills both result slots. TAG_W is narrowed to 4 so that a small set of tags covers every slot. The reference model is compared against the design on every cycle through directed sequences and a long stretch of random classes, flushes and valid gaps.

// File: rtl/fpht_pkg.sv
package fpht_pkg;

   typedef enum logic [3:0] {
      FC_NONE    = 4'd0,
      FC_ADD     = 4'd1,
      FC_CONST   = 4'd2,
      FC_MUL_SP  = 4'd3,
      FC_MUL_DP  = 4'd4,
      FC_FMA_DP  = 4'd5,
      FC_VEC_MUL = 4'd6,
      FC_DIV_SP  = 4'd7,
      FC_DIV_DP  = 4'd8,
      FC_MOVE    = 4'd9
   } fp_class_e;

   function automatic logic cls_is_mul(input logic [3:0] c);
      return (c == FC_MUL_SP) || (c == FC_MUL_DP) ||
             (c == FC_FMA_DP) || (c == FC_VEC_MUL);
   endfunction

   function automatic logic cls_is_div(input logic [3:0] c);
      return (c == FC_DIV_SP) || (c == FC_DIV_DP);
   endfunction

   function automatic logic cls_is_add(input logic [3:0] c);
      return (c == FC_ADD) || (c == FC_CONST);
   endfunction

endpackage

// File: rtl/fpht_hold_counter.sv
module fpht_hold_counter #(
   parameter int MAX_HOLD = 3,
   localparam int W = (MAX_HOLD < 1) ? 1 : $clog2(MAX_HOLD + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         held
);

   logic [W-1:0] cnt_q;

   if (MAX_HOLD < 1) begin : g_bad_max
      $error("fpht_hold_counter: MAX_HOLD must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (clr)           cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign held = (cnt_q != '0);

endmodule

// File: rtl/fpht_div_tracker.sv
module fpht_div_tracker #(
   parameter int SLOTS  = 2,
   parameter int TAG_W  = 5,
   parameter int LAT_SP = 16,
   parameter int LAT_DP = 31,
   localparam int LW = $clog2(LAT_DP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             start,
   input  logic             start_dp,
   input  logic [TAG_W-1:0] start_tag,
   output logic             space,
   output logic             done,
   output logic [TAG_W-1:0] done_tag
);

   localparam logic [LW-1:0] LOAD_SP = LW'(LAT_SP);
   localparam logic [LW-1:0] LOAD_DP = LW'(LAT_DP);

   logic [SLOTS-1:0]             free_v;
   logic [SLOTS-1:0]             fin_v;
   logic [SLOTS-1:0]             grant_v;
   logic [SLOTS-1:0][TAG_W-1:0]  fin_tag;

   if (SLOTS < 1) begin : g_bad_slots
      $error("fpht_div_tracker: SLOTS must be at least 1");
   end
   if (LAT_SP < 2 || LAT_DP < 2) begin : g_bad_lat
      $error("fpht_div_tracker: latencies must be at least 2");
   end

   always_comb begin
      logic found;
      found   = 1'b0;
      grant_v = '0;
      for (int i = 0; i < SLOTS; i++) begin
         if (free_v[i] && !found) begin
            grant_v[i] = 1'b1;
            found      = 1'b1;
         end
      end
   end

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic [LW-1:0]    cnt_q;
      logic [TAG_W-1:0] tag_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
            tag_q <= '0;
         end else if (clr) begin
            cnt_q <= '0;
         end else if (start && grant_v[g]) begin
            cnt_q <= start_dp ? LOAD_DP : LOAD_SP;
            tag_q <= start_tag;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end

      assign free_v[g]  = (cnt_q == '0);
      assign fin_v[g]   = (cnt_q == LW'(1));
      assign fin_tag[g] = fin_v[g] ? tag_q : '0;
   end

   always_comb begin
      done_tag = '0;
      for (int i = 0; i < SLOTS; i++) done_tag = done_tag | fin_tag[i];
   end

   assign done  = |fin_v;
   assign space = |free_v;

   // R9: two results never complete in the same cycle
   assert_single_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fin_v));

   // R9: a completing slot reports only once
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !(start && grant_v == fin_v)) |=> !(fin_v & $past(fin_v)));

endmodule

// File: rtl/fpht_issue_ctrl.sv
module fpht_issue_ctrl
   import fpht_pkg::*;
(
   input  logic [3:0] op_class,
   input  logic       flush,
   input  logic       slot_hold,
   input  logic       mul_held,
   input  logic       div_held,
   input  logic       div_space,
   output logic       issue_ok
);

   always_comb begin
      if (flush || slot_hold) begin
         issue_ok = 1'b0;
      end else if (cls_is_mul(op_class)) begin
         issue_ok = !mul_held;
      end else if (cls_is_div(op_class)) begin
         issue_ok = !div_held && div_space;
      end else begin
         issue_ok = 1'b1;
      end
   end

endmodule

// File: rtl/fp_hazard_tracker.sv
module fp_hazard_tracker
   import fpht_pkg::*;
#(
   parameter int TAG_W          = 5,
   parameter int MUL_DP_HOLD    = 3,
   parameter int FMA_DP_HOLD    = 4,
   parameter int VEC_MUL_CYCLES = 2,
   parameter int DIV_SP_HOLD    = 13,
   parameter int DIV_DP_HOLD    = 28,
   parameter int DIV_SP_LAT     = 16,
   parameter int DIV_DP_LAT     = 31,
   parameter int DONE_SLOTS     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             op_valid,
   input  logic [3:0]       op_class,
   input  logic [TAG_W-1:0] op_tag,
   output logic             issue_ok,
   output logic             mul_busy,
   output logic             add_busy,
   output logic             div_busy,
   output logic             div_done,
   output logic [TAG_W-1:0] div_done_tag
);

   localparam int VEC_HOLD = VEC_MUL_CYCLES - 1;
   localparam int MUL_MAX  = (MUL_DP_HOLD > FMA_DP_HOLD)
                           ? ((MUL_DP_HOLD > VEC_HOLD) ? MUL_DP_HOLD : VEC_HOLD)
                           : ((FMA_DP_HOLD > VEC_HOLD) ? FMA_DP_HOLD : VEC_HOLD);
   localparam int DIV_MAX  = (DIV_DP_HOLD > DIV_SP_HOLD) ? DIV_DP_HOLD : DIV_SP_HOLD;
   localparam int MUL_W    = $clog2(MUL_MAX + 1);
   localparam int DIV_W    = $clog2(DIV_MAX + 1);
   localparam int VEC_W    = (VEC_HOLD < 2) ? 1 : $clog2(VEC_HOLD + 1);

   localparam logic [MUL_W-1:0] LD_MUL_DP = MUL_W'(MUL_DP_HOLD);
   localparam logic [MUL_W-1:0] LD_FMA_DP = MUL_W'(FMA_DP_HOLD);
   localparam logic [MUL_W-1:0] LD_VEC    = MUL_W'(VEC_HOLD);
   localparam logic [DIV_W-1:0] LD_DIV_SP = DIV_W'(DIV_SP_HOLD);
   localparam logic [DIV_W-1:0] LD_DIV_DP = DIV_W'(DIV_DP_HOLD);
   localparam logic [VEC_W-1:0] LD_SLOT   = VEC_W'(VEC_HOLD);

   // elaboration-time parameter checks
   if (TAG_W < 1) begin : g_bad_tag
      $error("fp_hazard_tracker: TAG_W must be at least 1");
   end
   if (VEC_MUL_CYCLES < 2) begin : g_bad_vec
      $error("fp_hazard_tracker: VEC_MUL_CYCLES must be at least 2");
   end
   if (MUL_DP_HOLD < 1 || FMA_DP_HOLD < 1) begin : g_bad_mul
      $error("fp_hazard_tracker: multiply holds must be at least 1");
   end
   if (DIV_SP_LAT <= DIV_SP_HOLD || DIV_DP_LAT <= DIV_DP_HOLD) begin : g_bad_div
      $error("fp_hazard_tracker: divide latency must exceed its hold");
   end

   logic accept;
   logic acc_mul, acc_div, acc_add, acc_vec;
   logic mul_held, div_held, slot_hold, div_space;
   logic [MUL_W-1:0] mul_load_val;
   logic             mul_load;
   logic [DIV_W-1:0] div_load_val;

   fpht_issue_ctrl i_issue (
      .op_class  (op_class),
      .flush     (flush),
      .slot_hold (slot_hold),
      .mul_held  (mul_held),
      .div_held  (div_held),
      .div_space (div_space),
      .issue_ok  (issue_ok)
   );

   assign accept  = op_valid && issue_ok;
   assign acc_mul = accept && cls_is_mul(op_class);
   assign acc_div = accept && cls_is_div(op_class);
   assign acc_add = accept && cls_is_add(op_class);
   assign acc_vec = accept && (op_class == FC_VEC_MUL);

   always_comb begin
      mul_load     = 1'b0;
      mul_load_val = '0;
      if (accept) begin
         case (op_class)
            FC_MUL_DP:  begin mul_load = 1'b1; mul_load_val = LD_MUL_DP; end
            FC_FMA_DP:  begin mul_load = 1'b1; mul_load_val = LD_FMA_DP; end
            FC_VEC_MUL: begin mul_load = 1'b1; mul_load_val = LD_VEC;    end
            default:    ;
         endcase
      end
   end

   assign div_load_val = (op_class == FC_DIV_DP) ? LD_DIV_DP : LD_DIV_SP;

   fpht_hold_counter #(.MAX_HOLD(MUL_MAX)) i_mul_hold (
      .clk (clk), .rst_n (rst_n), .clr (flush),
      .load (mul_load), .load_val (mul_load_val), .held (mul_held)
   );

   fpht_hold_counter #(.MAX_HOLD(DIV_MAX)) i_div_hold (
      .clk (clk), .rst_n (rst_n), .clr (flush),
      .load (acc_div), .load_val (div_load_val), .held (div_held)
   );

   fpht_hold_counter #(.MAX_HOLD(VEC_HOLD)) i_slot_hold (
      .clk (clk), .rst_n (rst_n), .clr (flush),
      .load (acc_vec), .load_val (LD_SLOT), .held (slot_hold)
   );

   fpht_div_tracker #(
      .SLOTS (DONE_SLOTS), .TAG_W (TAG_W),
      .LAT_SP (DIV_SP_LAT), .LAT_DP (DIV_DP_LAT)
   ) i_div_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (flush),
      .start     (acc_div),
      .start_dp  (op_class == FC_DIV_DP),
      .start_tag (op_tag),
      .space     (div_space),
      .done      (div_done),
      .done_tag  (div_done_tag)
   );

   assign mul_busy = mul_held || acc_mul;
   assign div_busy = div_held || acc_div;
   assign add_busy = acc_add;

   // R3: the cycle after a double-precision multiply issues, the pipe is still held
   assert_dp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (op_class == FC_MUL_DP || op_class == FC_FMA_DP) && !flush)
      |=> mul_busy);

   // R4: a multiply never issues while the pipe is held by an earlier one
   assert_mul_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mul_held && cls_is_mul(op_class)) |-> !issue_ok);

   // R6: the cycle after a vector multiply issues, nothing issues
   assert_vec_slots_R6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_vec |=> !issue_ok);

   // R7: the add pipe is in use only when an operation is accepted
   assert_add_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
      add_busy |-> (op_valid && issue_ok));

   // R8: a divide never issues into a held divider
   assert_div_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (div_held && cls_is_div(op_class)) |-> !issue_ok);

   // R10: a flush leaves every hold released
   assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!mul_held && !div_held && !slot_hold && !div_done));

endmodule

// File: tb/test_fp_hazard_tracker.sv
`timescale 1ns/1ps
module test_fp_hazard_tracker;

   localparam int TW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic          op_valid = 1'b0;
   logic [3:0]    op_class = 4'd0;
   logic [TW-1:0] op_tag = '0;
   logic          issue_ok, mul_busy, add_busy, div_busy, div_done;
   logic [TW-1:0] div_done_tag;

   int errors = 0;
   int checks = 0;

   // reference model state
   int m_mul = 0;
   int m_div = 0;
   int m_vec = 0;
   int q_due[$];
   int q_tag[$];

   always #2 clk = ~clk;

   fp_hazard_tracker #(.TAG_W(TW)) i_fp_hazard_tracker (
      .clk (clk), .rst_n (rst_n), .flush (flush),
      .op_valid (op_valid), .op_class (op_class), .op_tag (op_tag),
      .issue_ok (issue_ok), .mul_busy (mul_busy), .add_busy (add_busy),
      .div_busy (div_busy), .div_done (div_done), .div_done_tag (div_done_tag)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // one cycle: drive, compare against the model, advance the model at the edge
   task automatic step(input bit v, input int c, input int tg, input bit fl, input string req);
      bit is_mul, is_div, is_add, e_ok, acc, e_done;
      int e_tag;
      int nd[$];
      int nt[$];
      @(negedge clk);
      op_valid = v; op_class = c[3:0]; op_tag = tg[TW-1:0]; flush = fl;
      #1;
      is_mul = (c >= 3 && c <= 6);
      is_div = (c == 7 || c == 8);
      is_add = (c == 1 || c == 2);
      if (fl || m_vec > 0)  e_ok = 0;
      else if (is_mul)      e_ok = (m_mul == 0);
      else if (is_div)      e_ok = (m_div == 0) && (q_due.size() < 2);
      else                  e_ok = 1;
      acc = v && e_ok;
      e_done = 0; e_tag = 0;
      foreach (q_due[i]) if (q_due[i] == 1) begin e_done = 1; e_tag = q_tag[i]; end
      chk(req, "issue_ok", issue_ok, e_ok);
      chk(req, "mul_busy", mul_busy, (m_mul > 0) || (acc && is_mul));
      chk(req, "div_busy", div_busy, (m_div > 0) || (acc && is_div));
      chk(req, "add_busy", add_busy, acc && is_add);
      chk(req, "div_done", div_done, e_done);
      if (e_done) chk(req, "div_done_tag", div_done_tag, e_tag);
      @(posedge clk);
      foreach (q_due[i]) if (q_due[i] > 1) begin nd.push_back(q_due[i] - 1); nt.push_back(q_tag[i]); end
      q_due = nd; q_tag = nt;
      if (m_mul > 0) m_mul--;
      if (m_div > 0) m_div--;
      if (m_vec > 0) m_vec--;
      if (fl) begin
         m_mul = 0; m_div = 0; m_vec = 0; q_due.delete(); q_tag.delete();
      end else if (acc) begin
         case (c)
            4: m_mul = 3;
            5: m_mul = 4;
            6: begin m_mul = 1; m_vec = 1; end
            7: begin m_div = 13; q_due.push_back(16); q_tag.push_back(tg); end
            8: begin m_div = 28; q_due.push_back(31); q_tag.push_back(tg); end
            default: ;
         endcase
      end
   endtask

   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, req);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      int seen;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: every class may issue out of reset, nothing busy
      for (int c = 0; c < 16; c++) step(0, c, 0, 0, "R1");

      // R3 / R4 / R5: double-precision multiply then retries and non-multiplies
      step(1, 4, 0, 0, "R3");
      step(1, 3, 0, 0, "R4");
      step(1, 1, 0, 0, "R5");
      step(1, 5, 0, 0, "R4");
      step(1, 3, 0, 0, "R3");
      step(1, 5, 0, 0, "R3");
      for (int i = 0; i < 4; i++) step(1, 6, 0, 0, "R4");
      step(1, 3, 0, 0, "R3");
      step(1, 9, 0, 0, "R5");

      // R6: vector multiply blocks both slots the next cycle
      step(1, 6, 0, 0, "R6");
      step(1, 1, 0, 0, "R6");
      step(1, 3, 0, 0, "R6");
      step(1, 6, 0, 0, "R6");
      step(1, 7, 2, 0, "R6");
      idle(20, "R9");

      // R7 / R2: add pipe use and valid gating
      step(1, 1, 0, 0, "R7");
      step(1, 2, 0, 0, "R7");
      step(0, 1, 0, 0, "R2");
      step(1, 9, 0, 0, "R7");
      step(1, 12, 0, 0, "R2");
      step(0, 4, 0, 0, "R2");
      step(1, 3, 0, 0, "R2");

      // R8 / R9: single-precision divide, then a double-precision one retried
      step(1, 7, 3, 0, "R8");
      for (int i = 0; i < 14; i++) step(1, (i == 5) ? 4 : 8, 5, 0, "R8");
      idle(40, "R9");

      // R9: exact completion cycle of a single-precision divide
      step(1, 7, 11, 0, "R9");
      seen = -1;
      for (int i = 1; i <= 20; i++) begin
         step(0, 0, 0, 0, "R9");
         if (div_done && seen < 0) seen = i;
      end
      chk("R9", "done cycle", seen, 16);

      // R10: flush drops holds and a pending result
      step(1, 8, 7, 0, "R10");
      step(1, 4, 0, 0, "R10");
      step(1, 1, 0, 1, "R10");
      step(1, 3, 0, 0, "R10");
      step(1, 7, 6, 0, "R10");
      step(1, 6, 0, 1, "R10");
      idle(40, "R10");

      // R2: long mixed stream
      for (int i = 0; i < 3000; i++)
         step($urandom_range(0, 3) != 0, $urandom_range(0, 15), $urandom_range(0, 15),
              $urandom_range(0, 60) == 0, "R2");
      idle(35, "R9");

      summary();
      $finish;
   end

endmodule